// File: doc/BRIEF.md
# Dual-Bank Byte-Steering Bus Controller

This block sits between a 16-bit requester and a memory built from two 8-bit banks. One bank holds the even byte addresses and the other holds the odd ones, across a 20-bit byte address space. Each request carries a byte address, a size flag (byte or word), a direction flag and write data. The block drives an active-low high-bank enable together with address bit 0 to pick the banks. It moves bytes between the requester and the correct half of the 16-bit data bus. A word that starts at an odd address becomes two bus cycles with the byte lanes crossed.

Each bus cycle lasts one clock. The memory returns read data within that clock and takes write data at its closing edge. Read data always reaches the requester right-aligned: the lower-addressed byte is in bits 7..0, and a byte read returns zero in bits 15..8. The requester uses a valid/ready handshake. A request is taken only when the block is idle, and a one-clock done pulse marks the end of it.

Top module: `dual_bank_steer`

## Requirements
- R1: While reset is held, and after it, until a request is accepted, the block is idle: `bus_bhe_n`=1, `bus_addr[0]`=1, `bus_we`=0, `rsp_done`=0 and `req_ready`=1.
- R2: A byte request at an even address makes exactly one bus cycle with `bus_bhe_n`=1 and `bus_addr[0]`=0, and the byte travels on `bus_wdata[7:0]`.
- R3: A byte request at an odd address makes exactly one bus cycle with `bus_bhe_n`=0 and `bus_addr[0]`=1, and the byte travels on `bus_wdata[15:8]`.
- R4: A word request at an even address makes exactly one bus cycle at that address with `bus_bhe_n`=0 and `bus_addr[0]`=0. The low byte is on lines 7..0 and the high byte on lines 15..8.
- R5: A word request at odd address N makes two consecutive bus cycles. The first is at N with `bus_bhe_n`=0 and `bus_addr[0]`=1, carrying the low byte on lines 15..8. The second is at N+1 with `bus_bhe_n`=1 and `bus_addr[0]`=0, carrying the high byte on lines 7..0.
- R6: The second cycle of a word at FFFFFH uses address 00000H.
- R7: On a completed read, `rsp_rdata[7:0]` holds the byte at the request address. For a word, `rsp_rdata[15:8]` holds the byte at the next address. For a byte read it is zero.
- R8: `req_ready` is low during every bus cycle, and `req_valid` has no effect while the block is busy: the bus cycles and the result of the current request do not change.
- R9: `rsp_done` is high for exactly one clock. It rises two clock edges after the accepting edge for a single-cycle request and three edges after it for an odd-address word.
- R10: `bus_we` equals the request's write flag during each of its bus cycles. A write changes only the bytes it addresses: other memory bytes keep their values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request can be taken |
| req_addr | input | 20 | Byte address |
| req_word | input | 1 | 1 = 16-bit word, 0 = byte |
| req_write | input | 1 | 1 = write, 0 = read |
| req_wdata | input | 16 | Write data; low byte in bits 7..0 |
| rsp_done | output | 1 | One-clock completion pulse |
| rsp_rdata | output | 16 | Realigned read data, valid with `rsp_done` on reads |
| bus_addr | output | 20 | Bus byte address; bit 0 is the bank select line |
| bus_bhe_n | output | 1 | Active-low high-bank enable |
| bus_we | output | 1 | Bus write strobe |
| bus_wdata | output | 16 | Bus write data, lanes steered |
| bus_rdata | input | 16 | Bus read data from both banks |

## Verification
The accepting edge is the bench's time reference. The first bus cycle is visible one clock later. An odd-address word's second cycle follows one clock after that. `rsp_done` and `rsp_rdata` come one edge after the last bus cycle, so they appear two edges after acceptance for a single-cycle request and three for a split word. The bench drives and samples on falling edges. It counts those falling edges from acceptance, records each active bus cycle in the order it appears, and compares the recorded count and the latency against the values each requirement predicts.

// File: rtl/dbs_pkg.sv
package dbs_pkg;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_FIRST  = 2'd1,
    ST_SECOND = 2'd2
  } seq_state_e;

  typedef struct packed {
    logic word;
    logic write;
  } req_kind_t;

endpackage

// File: rtl/dbs_rst_sync.sv
module dbs_rst_sync (
  input  logic clk,
  input  logic rst_n,
  output logic rst_n_sync
);
  logic meta_q;
  logic hold_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      meta_q <= 1'b0;
      hold_q <= 1'b0;
    end else begin
      meta_q <= 1'b1;
      hold_q <= meta_q;
    end
  end

  assign rst_n_sync = hold_q;
endmodule

// File: rtl/dbs_seq.sv
module dbs_seq
  import dbs_pkg::*;
(
  input  logic       clk,
  input  logic       rst_n,
  input  logic       req_valid,
  input  logic       split_q,
  output seq_state_e state_q,
  output logic       accept,
  output logic       done_q
);
  seq_state_e state_d;
  logic       last_cycle;
  logic       done_d;

  assign accept = req_valid && (state_q == ST_IDLE);

  always_comb begin
    state_d    = state_q;
    last_cycle = 1'b0;
    unique case (state_q)
      ST_IDLE: begin
        if (req_valid) state_d = ST_FIRST;
      end
      ST_FIRST: begin
        if (split_q) begin
          state_d = ST_SECOND;
        end else begin
          state_d    = ST_IDLE;
          last_cycle = 1'b1;
        end
      end
      ST_SECOND: begin
        state_d    = ST_IDLE;
        last_cycle = 1'b1;
      end
      default: state_d = ST_IDLE;
    endcase
    done_d = last_cycle;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      done_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      done_q  <= done_d;
    end
  end
endmodule

// File: rtl/dbs_lane_plan.sv
module dbs_lane_plan
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  seq_state_e          state_q,
  input  logic [ADDR_W-1:0]   addr_q,
  input  req_kind_t           kind_q,
  input  logic [DATA_W-1:0]   wdata_q,
  output logic [ADDR_W-1:0]   bus_addr,
  output logic                bus_bhe_n,
  output logic                bus_we,
  output logic [DATA_W-1:0]   bus_wdata
);
  localparam logic [ADDR_W-1:0] IDLE_ADDR = ADDR_W'(1);
  localparam logic [ADDR_W-1:0] ONE       = ADDR_W'(1);

  logic [BYTE_W-1:0] lo_byte;
  logic [BYTE_W-1:0] hi_byte;
  logic              aligned_word;

  assign lo_byte      = wdata_q[BYTE_W-1:0];
  assign hi_byte      = wdata_q[DATA_W-1:BYTE_W];
  assign aligned_word = kind_q.word && !addr_q[0];

  always_comb begin
    bus_addr  = IDLE_ADDR;
    bus_bhe_n = 1'b1;
    bus_we    = 1'b0;
    bus_wdata = '0;
    unique case (state_q)
      ST_FIRST: begin
        bus_addr  = addr_q;
        bus_bhe_n = kind_q.word ? 1'b0 : ~addr_q[0];
        bus_we    = kind_q.write;
        bus_wdata = aligned_word ? wdata_q : {lo_byte, lo_byte};
      end
      ST_SECOND: begin
        bus_addr  = addr_q + ONE;
        bus_bhe_n = 1'b1;
        bus_we    = kind_q.write;
        bus_wdata = {hi_byte, hi_byte};
      end
      default: ;
    endcase
  end
endmodule

// File: rtl/dbs_read_align.sv
module dbs_read_align
  import dbs_pkg::*;
#(
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  seq_state_e        state_q,
  input  logic              word_q,
  input  logic              a0_q,
  input  logic [DATA_W-1:0] bus_rdata,
  output logic [DATA_W-1:0] rsp_rdata
);
  logic [BYTE_W-1:0] lo_d, hi_d;
  logic              lo_en, hi_en;
  logic [BYTE_W-1:0] lane_lo, lane_hi;

  assign lane_lo = bus_rdata[BYTE_W-1:0];
  assign lane_hi = bus_rdata[DATA_W-1:BYTE_W];

  always_comb begin
    lo_en = 1'b0;
    hi_en = 1'b0;
    lo_d  = '0;
    hi_d  = '0;
    if (state_q == ST_FIRST) begin
      lo_en = 1'b1;
      lo_d  = a0_q ? lane_hi : lane_lo;
      if (!word_q) begin
        hi_en = 1'b1;
        hi_d  = '0;
      end else if (!a0_q) begin
        hi_en = 1'b1;
        hi_d  = lane_hi;
      end
    end else if (state_q == ST_SECOND) begin
      hi_en = 1'b1;
      hi_d  = lane_lo;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rsp_rdata <= '0;
    end else begin
      if (lo_en) rsp_rdata[BYTE_W-1:0]      <= lo_d;
      if (hi_en) rsp_rdata[DATA_W-1:BYTE_W] <= hi_d;
    end
  end
endmodule

// File: rtl/dual_bank_steer.sv
module dual_bank_steer
  import dbs_pkg::*;
#(
  parameter int ADDR_W = 20,
  parameter int BYTE_W = 8,
  localparam int DATA_W = 2 * BYTE_W
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              req_valid,
  output logic              req_ready,
  input  logic [ADDR_W-1:0] req_addr,
  input  logic              req_word,
  input  logic              req_write,
  input  logic [DATA_W-1:0] req_wdata,
  output logic              rsp_done,
  output logic [DATA_W-1:0] rsp_rdata,
  output logic [ADDR_W-1:0] bus_addr,
  output logic              bus_bhe_n,
  output logic              bus_we,
  output logic [DATA_W-1:0] bus_wdata,
  input  logic [DATA_W-1:0] bus_rdata
);
  logic              rst_n_i;
  seq_state_e        state_q;
  logic              accept;
  logic [ADDR_W-1:0] addr_q;
  req_kind_t         kind_q;
  logic [DATA_W-1:0] wdata_q;
  logic              split_q;

  dbs_rst_sync u_rst (
    .clk       (clk),
    .rst_n     (rst_n),
    .rst_n_sync(rst_n_i)
  );

  dbs_seq u_seq (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .req_valid(req_valid),
    .split_q  (split_q),
    .state_q  (state_q),
    .accept   (accept),
    .done_q   (rsp_done)
  );

  always_ff @(posedge clk or negedge rst_n_i) begin
    if (!rst_n_i) begin
      addr_q  <= '0;
      kind_q  <= '0;
      wdata_q <= '0;
      split_q <= 1'b0;
    end else if (accept) begin
      addr_q       <= req_addr;
      kind_q.word  <= req_word;
      kind_q.write <= req_write;
      wdata_q      <= req_wdata;
      split_q      <= req_word && req_addr[0];
    end
  end

  dbs_lane_plan #(.ADDR_W(ADDR_W), .BYTE_W(BYTE_W)) u_plan (
    .state_q  (state_q),
    .addr_q   (addr_q),
    .kind_q   (kind_q),
    .wdata_q  (wdata_q),
    .bus_addr (bus_addr),
    .bus_bhe_n(bus_bhe_n),
    .bus_we   (bus_we),
    .bus_wdata(bus_wdata)
  );

  dbs_read_align #(.BYTE_W(BYTE_W)) u_align (
    .clk      (clk),
    .rst_n    (rst_n_i),
    .state_q  (state_q),
    .word_q   (kind_q.word),
    .a0_q     (addr_q[0]),
    .bus_rdata(bus_rdata),
    .rsp_rdata(rsp_rdata)
  );

  assign req_ready = (state_q == ST_IDLE);
endmodule

// File: rtl/dbs_checker.sv
module dbs_checker #(
  parameter int ADDR_W = 20
) (
  input logic              clk,
  input logic              rst_n,
  input logic              req_valid,
  input logic              req_ready,
  input logic [ADDR_W-1:0] req_addr,
  input logic              req_word,
  input logic              req_write,
  input logic [ADDR_W-1:0] bus_addr,
  input logic              bus_bhe_n,
  input logic              bus_we,
  input logic              rsp_done
);
  logic acc;
  assign acc = req_valid && req_ready;

  // R1 / R8: the idle code appears exactly when the block is ready
  p_idle_code_r1: assert property (@(posedge clk) disable iff (!rst_n)
    req_ready == (bus_bhe_n && bus_addr[0]));

  // R2 / R3: a byte request enables exactly one lane
  p_byte_lane_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && !req_word) |=> (bus_bhe_n != bus_addr[0]) ##1 rsp_done);

  // R4: aligned word uses both lanes in one cycle
  p_even_word_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_word && !req_addr[0]) |=> (!bus_bhe_n && !bus_addr[0]) ##1 rsp_done);

  // R5: odd word first cycle at the request address
  p_odd_first_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_word && req_addr[0]) |=>
      (!bus_bhe_n && bus_addr[0] && bus_addr == $past(req_addr)));

  // R6: odd word second cycle at the next address, wrapping
  p_odd_second_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (acc && req_word && req_addr[0]) |=> ##1
      (bus_bhe_n && !bus_addr[0] && bus_addr == ADDR_W'($past(req_addr, 2) + ADDR_W'(1))));

  // R9: done is a single-clock pulse
  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_done |=> !rsp_done);

  // R10: write strobe follows the request direction
  p_we_dir_r10: assert property (@(posedge clk) disable iff (!rst_n)
    acc |=> (bus_we == $past(req_write)));
endmodule

bind dual_bank_steer dbs_checker #(.ADDR_W(ADDR_W)) u_chk (
  .clk      (clk),
  .rst_n    (rst_n),
  .req_valid(req_valid),
  .req_ready(req_ready),
  .req_addr (req_addr),
  .req_word (req_word),
  .req_write(req_write),
  .bus_addr (bus_addr),
  .bus_bhe_n(bus_bhe_n),
  .bus_we   (bus_we),
  .rsp_done (rsp_done)
);

// File: tb/dual_bank_steer_tb.sv
module dual_bank_steer_tb_top;
  localparam int MEM_AW = 10;
  localparam int MEM_N  = 1 << MEM_AW;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic        req_ready;
  logic [19:0] req_addr = '0;
  logic        req_word = 1'b0;
  logic        req_write = 1'b0;
  logic [15:0] req_wdata = '0;
  logic        rsp_done;
  logic [15:0] rsp_rdata;
  logic [19:0] bus_addr;
  logic        bus_bhe_n;
  logic        bus_we;
  logic [15:0] bus_wdata;
  logic [15:0] bus_rdata;

  logic [7:0] mem     [MEM_N];
  logic [7:0] ref_mem [MEM_N];

  int checks = 0;
  int fails  = 0;
  bit finished = 0;

  logic [19:0] tr_addr [2];
  logic        tr_bhe  [2];
  logic [15:0] tr_wd   [2];
  logic        tr_we   [2];
  bit          ready_in_busy;
  bit          done_stuck;

  always #4 clk = ~clk;

  dual_bank_steer dut_i (.*);

  // memory model: one-cycle access, combinational read, write at closing edge
  logic [MEM_AW-1:0] ev_idx, od_idx;
  assign ev_idx    = {bus_addr[MEM_AW-1:1], 1'b0};
  assign od_idx    = {bus_addr[MEM_AW-1:1], 1'b1};
  assign bus_rdata = {mem[od_idx], mem[ev_idx]};

  always @(posedge clk) begin
    if (bus_we && !bus_addr[0]) mem[ev_idx] <= bus_wdata[7:0];
    if (bus_we && !bus_bhe_n)   mem[od_idx] <= bus_wdata[15:8];
  end

  task automatic chk(input string rq, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", rq, act, exp);
    end
  endtask

  function automatic logic [15:0] exp_read(input logic [19:0] a, input logic w);
    logic [19:0] b;
    b = a + 20'd1;
    return w ? {ref_mem[b[MEM_AW-1:0]], ref_mem[a[MEM_AW-1:0]]}
             : {8'h00, ref_mem[a[MEM_AW-1:0]]};
  endfunction

  task automatic ref_write(input logic [19:0] a, input logic w, input logic [15:0] d);
    logic [19:0] b;
    b = a + 20'd1;
    ref_mem[a[MEM_AW-1:0]] = d[7:0];
    if (w) ref_mem[b[MEM_AW-1:0]] = d[15:8];
  endtask

  task automatic do_req(input logic [19:0] a, input logic w, input logic wr,
                        input logic [15:0] d, input bit noise,
                        output logic [15:0] rd, output int ncyc, output int lat);
    @(negedge clk);
    req_valid = 1'b1; req_addr = a; req_word = w; req_write = wr; req_wdata = d;
    @(posedge clk);
    @(negedge clk);
    if (noise) begin
      req_addr = 20'h55555; req_word = 1'b0; req_write = ~wr; req_wdata = 16'h1234;
    end else begin
      req_valid = 1'b0;
    end
    lat = 1; ncyc = 0; ready_in_busy = 0; done_stuck = 0;
    for (int k = 0; k < 8; k++) begin
      if (rsp_done) break;
      if (!(bus_bhe_n && bus_addr[0])) begin
        if (ncyc < 2) begin
          tr_addr[ncyc] = bus_addr; tr_bhe[ncyc] = bus_bhe_n;
          tr_wd[ncyc] = bus_wdata;  tr_we[ncyc] = bus_we;
        end
        ncyc++;
        if (req_ready) ready_in_busy = 1;
      end
      @(negedge clk);
      lat++;
    end
    req_valid = 1'b0;
    rd = rsp_rdata;
    @(negedge clk);
    if (rsp_done) done_stuck = 1;
    if (wr) ref_write(a, w, d);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      fails++; checks++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [15:0] rd;
    int nc, lt;
    for (int i = 0; i < MEM_N; i++) begin
      mem[i] = 8'(i * 7 + 3);
      ref_mem[i] = 8'(i * 7 + 3);
    end
    repeat (3) @(negedge clk);
    // R1 reset state
    chk("R1 bhe_n", 32'(bus_bhe_n), 32'd1);
    chk("R1 a0", 32'(bus_addr[0]), 32'd1);
    chk("R1 done", 32'(rsp_done), 32'd0);
    chk("R1 we", 32'(bus_we), 32'd0);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    chk("R1 ready", 32'(req_ready), 32'd1);

    // R2 even byte write
    do_req(20'h00100, 1'b0, 1'b1, 16'h00A5, 0, rd, nc, lt);
    chk("R2 cycles", 32'(nc), 32'd1);
    chk("R2 select", {tr_bhe[0], tr_addr[0][0]}, {1'b1, 1'b0});
    chk("R2 lane", 32'(tr_wd[0][7:0]), 32'hA5);
    chk("R9 latency single", 32'(lt), 32'd2);
    chk("R10 we write", 32'(tr_we[0]), 32'd1);

    // R3 odd byte write
    do_req(20'h00101, 1'b0, 1'b1, 16'h003C, 0, rd, nc, lt);
    chk("R3 cycles", 32'(nc), 32'd1);
    chk("R3 select", {tr_bhe[0], tr_addr[0][0]}, {1'b0, 1'b1});
    chk("R3 lane", 32'(tr_wd[0][15:8]), 32'h3C);

    // R4 even word write then read
    do_req(20'h00200, 1'b1, 1'b1, 16'hCAFE, 0, rd, nc, lt);
    chk("R4 cycles", 32'(nc), 32'd1);
    chk("R4 select", {tr_bhe[0], tr_addr[0][0]}, {1'b0, 1'b0});
    chk("R4 data", 32'(tr_wd[0]), 32'hCAFE);
    do_req(20'h00200, 1'b1, 1'b0, 16'h0, 0, rd, nc, lt);
    chk("R7 word even read", 32'(rd), 32'(exp_read(20'h00200, 1'b1)));
    chk("R10 we read", 32'(tr_we[0]), 32'd0);

    // R5 odd word write
    do_req(20'h00123, 1'b1, 1'b1, 16'hBEEF, 0, rd, nc, lt);
    chk("R5 cycles", 32'(nc), 32'd2);
    chk("R5 first addr", 32'(tr_addr[0]), 32'h00123);
    chk("R5 first sel", {tr_bhe[0], tr_addr[0][0]}, {1'b0, 1'b1});
    chk("R5 first lane", 32'(tr_wd[0][15:8]), 32'hEF);
    chk("R5 second addr", 32'(tr_addr[1]), 32'h00124);
    chk("R5 second sel", {tr_bhe[1], tr_addr[1][0]}, {1'b1, 1'b0});
    chk("R5 second lane", 32'(tr_wd[1][7:0]), 32'hBE);
    chk("R9 latency split", 32'(lt), 32'd3);
    chk("R9 pulse", 32'(done_stuck), 32'd0);
    do_req(20'h00123, 1'b1, 1'b0, 16'h0, 0, rd, nc, lt);
    chk("R7 odd word read", 32'(rd), 32'hBEEF);

    // R6 wrap
    do_req(20'hFFFFF, 1'b1, 1'b1, 16'h9A6B, 0, rd, nc, lt);
    chk("R6 second addr", 32'(tr_addr[1]), 32'h00000);
    do_req(20'hFFFFF, 1'b1, 1'b0, 16'h0, 0, rd, nc, lt);
    chk("R6 read back", 32'(rd), 32'h9A6B);

    // R7 byte reads clear upper half
    do_req(20'h00101, 1'b0, 1'b0, 16'h0, 0, rd, nc, lt);
    chk("R7 odd byte read", 32'(rd), 32'h003C);
    do_req(20'h00100, 1'b0, 1'b0, 16'h0, 0, rd, nc, lt);
    chk("R7 even byte read", 32'(rd), 32'h00A5);

    // R8 valid held high with other fields while busy
    do_req(20'h00301, 1'b1, 1'b1, 16'h7788, 1, rd, nc, lt);
    chk("R8 ready low busy", 32'(ready_in_busy), 32'd0);
    chk("R8 second addr", 32'(tr_addr[1]), 32'h00302);
    chk("R8 cycles", 32'(nc), 32'd2);
    do_req(20'h00301, 1'b1, 1'b0, 16'h0, 0, rd, nc, lt);
    chk("R8 data kept", 32'(rd), 32'h7788);

    // constrained random mix
    void'($urandom(32'h5EED));
    for (int n = 0; n < 400; n++) begin
      logic [19:0] a;
      logic w, wr;
      logic [15:0] d, e;
      int en;
      a  = 20'($urandom);
      if (n % 5 == 0) a = {10'h3FF, a[9:0]};
      w  = 1'($urandom);
      wr = 1'($urandom);
      d  = w ? 16'($urandom) : {8'h00, 8'($urandom)};
      e  = exp_read(a, w);
      en = (w && a[0]) ? 2 : 1;
      do_req(a, w, wr, d, 1'($urandom_range(0, 3) == 0), rd, nc, lt);
      chk("R9 random latency", 32'(lt), 32'(en + 1));
      chk("R5 random cycles", 32'(nc), 32'(en));
      chk("R8 random ready", 32'(ready_in_busy), 32'd0);
      if (!wr) chk("R7 random read", 32'(rd), 32'(e));
    end

    // R10 lane isolation over whole memory
    begin
      int bad = 0;
      for (int i = 0; i < MEM_N; i++) if (mem[i] !== ref_mem[i]) bad++;
      chk("R10 memory image", 32'(bad), 32'd0);
    end

    finished = 1;
    $display("  TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule